// File: doc/BRIEF.md
# LCD Panel Control Register Bank with Interrupt

This block is the software-visible control side of a simple LCD controller. A 32-bit register port, addressed by byte offset, carries the panel configuration: the panel enable, the palette-load mode, the active-matrix (TFT) and monochrome selects, a two-bit interrupt mask, the panel size as minus-one fields, three timing words and a subpanel word. The configuration fields drive the pixel fetch and timing logic elsewhere through dedicated outputs.

The fetch engine reports three events as single-cycle pulses: a frame completed, the palette was loaded, and a synchronisation error. Each one sets a sticky status flag that software reads. Turning the panel on or off through the enable bit also changes these flags. A single registered interrupt line combines the flags. The sync error cannot be masked, and the other two pass only when their mask bit is set.

Top module: `lcdc_regs_top`

## Requirements
- R1: Offset 0x00 (control) reads as: enable at bit 0, monochrome at bit 1, mask at bits 4:3, TFT at bit 7 and again at bit 23, palette-load mode at bits 21:20. The bits of the last written control word selected by 0x01CFF300 are ORed in, and so is the constant 0xFE000C34.
- R2: Offset 0x04 stores width minus one from bits 9:0 and a timing field from bits 31:10. It reads back as the written word with bits 3:0 forced to 1.
- R3: Offset 0x08 stores height minus one from bits 9:0 and a timing field from bits 31:10. It reads back exactly as written.
- R4: Offset 0x0C stores the full written word and reads back ORed with 0xFC000000.
- R5: Offset 0x10 is read-only and writes to it change nothing. It reads frame done at bit 0, sync error at bit 2 and palette loaded at bit 6, with all other bits zero. A pulse on an event input sets its flag at that clock edge, and the flag stays set.
- R6: Offset 0x14 stores the written word ANDed with 0xA1FFFFFF.
- R7: Any other byte offset, unaligned ones included, reads as zero, and a write to it changes no register.
- R8: The interrupt output rises one clock after a flag condition appears: frame done with mask bit 0, palette loaded with mask bit 1, or sync error with either mask. It is low one clock after none of these holds.
- R9: A control write that changes enable from 1 to 0 clears sync error. It also sets frame done unless the newly written palette-load mode is 1, in which case frame done is left as it was. In that cycle this overrides a sync error pulse.
- R10: A control write that changes enable from 0 to 1 clears frame done and palette loaded. In that cycle this overrides pulses on those two events.
- R11: While reset is low, every stored field, every flag and the interrupt output are zero.
- R12: A write takes effect at the clock edge where the strobe is sampled. From then on the panel enable, mode, TFT, monochrome, width and height outputs show the stored fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_addr | input | 8 | Byte offset of the access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| evt_frame_done | input | 1 | Frame-complete pulse from the fetch engine |
| evt_palette_loaded | input | 1 | Palette-loaded pulse from the fetch engine |
| evt_sync_error | input | 1 | Sync-error pulse from the fetch engine |
| irq | output | 1 | Registered combined interrupt |
| panel_en | output | 1 | Stored panel enable |
| pal_mode | output | 2 | Stored palette-load mode |
| tft_sel | output | 1 | Stored active-matrix select |
| mono_sel | output | 1 | Stored monochrome select |
| width_m1 | output | 10 | Stored width minus one |
| height_m1 | output | 10 | Stored height minus one |

## Verification
A wrong stored field or flag is visible at once: the read port is combinational, so the value shows in the cycle after the faulty edge whenever that offset is addressed. The configuration outputs show a bad control or size field in that same cycle without any read. A wrong flag shows up at the status offset right away. It also shows on the interrupt line one clock later, so a flag that was set wrongly or cleared by the enable edges produces a mismatch within two cycles. The bench therefore compares the read data, the interrupt and every configuration output against its model on every clock, and it walks the read address over all offsets.

// File: rtl/lcdc_pkg.sv
package lcdc_pkg;
  localparam int DATA_W = 32;
  localparam int SIZE_W = 10;
  localparam int TFLD_W = DATA_W - SIZE_W;
  localparam int NFLAG  = 3;

  // flag indices; status bit positions are fixed by the read layout
  localparam int FLG_FRAME = 0;
  localparam int FLG_PAL   = 1;
  localparam int FLG_SYNC  = 2;

  localparam logic [DATA_W-1:0] CTRL_SET  = 32'hFE000C34;
  localparam logic [DATA_W-1:0] CTRL_KEEP = 32'h01CFF300;
  localparam logic [DATA_W-1:0] TIM2_SET  = 32'hFC000000;
  localparam logic [DATA_W-1:0] SUB_KEEP  = 32'hA1FFFFFF;
  localparam logic [3:0]        TIM0_LOW  = 4'hF;

  typedef struct packed {
    logic              en;
    logic              mono;
    logic [1:0]        mask;
    logic              tft;
    logic [1:0]        plm;
    logic [DATA_W-1:0] ctrl_kept;
    logic [SIZE_W-1:0] width_m1;
    logic [TFLD_W-1:0] tim0_hi;
    logic [SIZE_W-1:0] height_m1;
    logic [TFLD_W-1:0] tim1_hi;
    logic [DATA_W-1:0] tim2;
    logic [DATA_W-1:0] sub;
  } cfg_t;
endpackage

// File: rtl/lcdc_cfg_regs.sv
module lcdc_cfg_regs
  import lcdc_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output cfg_t              cfg_o,
  output logic              en_rise_o,
  output logic              en_fall_o,
  output logic              fall_sets_frame_o
);
  localparam logic [ADDR_W-1:0] OFS_CTRL = ADDR_W'('h00);
  localparam logic [ADDR_W-1:0] OFS_TIM0 = ADDR_W'('h04);
  localparam logic [ADDR_W-1:0] OFS_TIM1 = ADDR_W'('h08);
  localparam logic [ADDR_W-1:0] OFS_TIM2 = ADDR_W'('h0C);
  localparam logic [ADDR_W-1:0] OFS_SUB  = ADDR_W'('h14);

  cfg_t cfg_q, cfg_d;
  logic wr_ctrl, wr_tim0, wr_tim1, wr_tim2, wr_sub;

  assign wr_ctrl = wr_en && (addr == OFS_CTRL);
  assign wr_tim0 = wr_en && (addr == OFS_TIM0);
  assign wr_tim1 = wr_en && (addr == OFS_TIM1);
  assign wr_tim2 = wr_en && (addr == OFS_TIM2);
  assign wr_sub  = wr_en && (addr == OFS_SUB);

  always_comb begin
    cfg_d = cfg_q;
    if (wr_ctrl) begin
      cfg_d.en        = wdata[0];
      cfg_d.mono      = wdata[1];
      cfg_d.mask      = wdata[4:3];
      cfg_d.tft       = wdata[7];
      cfg_d.plm       = wdata[21:20];
      cfg_d.ctrl_kept = wdata & CTRL_KEEP;
    end
    if (wr_tim0) begin
      cfg_d.width_m1 = wdata[SIZE_W-1:0];
      cfg_d.tim0_hi  = wdata[DATA_W-1:SIZE_W];
    end
    if (wr_tim1) begin
      cfg_d.height_m1 = wdata[SIZE_W-1:0];
      cfg_d.tim1_hi   = wdata[DATA_W-1:SIZE_W];
    end
    if (wr_tim2) cfg_d.tim2 = wdata;
    if (wr_sub)  cfg_d.sub  = wdata & SUB_KEEP;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= '0;
    else        cfg_q <= cfg_d;
  end

  assign cfg_o             = cfg_q;
  assign en_rise_o         = wr_ctrl &&  wdata[0] && !cfg_q.en;
  assign en_fall_o         = wr_ctrl && !wdata[0] &&  cfg_q.en;
  assign fall_sets_frame_o = (wdata[21:20] != 2'd1);

  // R12: a size write lands at the sampling edge
  a_r12_width_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == OFS_TIM0) |=> (cfg_o.width_m1 == $past(wdata[SIZE_W-1:0])));
  // R7: writes to unmapped offsets leave every field alone
  a_r7_undef_write_inert: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr != OFS_CTRL && addr != OFS_TIM0 && addr != OFS_TIM1 &&
     addr != OFS_TIM2 && addr != OFS_SUB) |=> $stable(cfg_o));
  // R6: subpanel never holds the masked-off bits
  a_r6_sub_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_o.sub & ~SUB_KEEP) == '0);
endmodule

// File: rtl/lcdc_status_irq.sv
module lcdc_status_irq
  import lcdc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             evt_frame,
  input  logic             evt_pal,
  input  logic             evt_sync,
  input  logic             en_rise,
  input  logic             en_fall,
  input  logic             fall_sets_frame,
  input  logic [1:0]       mask,
  output logic [NFLAG-1:0] flags_o,
  output logic             irq_o
);
  logic [NFLAG-1:0] flag_q, flag_d, set_v, clr_v, force_v;
  logic             irq_q, irq_d;

  assign set_v = {evt_sync, evt_pal, evt_frame};

  always_comb begin
    clr_v   = '0;
    force_v = '0;
    if (en_rise) begin
      clr_v[FLG_FRAME] = 1'b1;
      clr_v[FLG_PAL]   = 1'b1;
    end
    if (en_fall) begin
      clr_v[FLG_SYNC]    = 1'b1;
      force_v[FLG_FRAME] = fall_sets_frame;
    end
  end

  for (genvar i = 0; i < NFLAG; i++) begin : g_flag
    assign flag_d[i] = force_v[i] | (~clr_v[i] & (flag_q[i] | set_v[i]));
  end

  assign irq_d = (flag_q[FLG_FRAME] & mask[0]) |
                 (flag_q[FLG_PAL]   & mask[1]) |
                  flag_q[FLG_SYNC];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      flag_q <= flag_d;
      irq_q  <= irq_d;
    end
  end

  assign flags_o = flag_q;
  assign irq_o   = irq_q;

  // R8: an unmasked sync error raises the line on the next edge
  a_r8_sync_unmasked: assert property (@(posedge clk) disable iff (!rst_n)
    flags_o[FLG_SYNC] |=> irq_o);
  // R8: nothing pending means the line is low on the next edge
  a_r8_quiet_low: assert property (@(posedge clk) disable iff (!rst_n)
    (!flags_o[FLG_SYNC] && !(flags_o[FLG_FRAME] && mask[0]) &&
     !(flags_o[FLG_PAL] && mask[1])) |=> !irq_o);
  // R9: switching off clears the sync error
  a_r9_fall_clears_sync: assert property (@(posedge clk) disable iff (!rst_n)
    en_fall |=> !flags_o[FLG_SYNC]);
  // R10: switching on clears frame done and palette loaded
  a_r10_rise_clears: assert property (@(posedge clk) disable iff (!rst_n)
    en_rise |=> (!flags_o[FLG_FRAME] && !flags_o[FLG_PAL]));
  // R5: flags are sticky without events or enable edges
  a_r5_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (!evt_frame && !evt_pal && !evt_sync && !en_rise && !en_fall) |=> $stable(flags_o));
endmodule

// File: rtl/lcdc_read_mux.sv
module lcdc_read_mux
  import lcdc_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr,
  input  cfg_t              cfg,
  input  logic [NFLAG-1:0]  flags,
  output logic [DATA_W-1:0] rdata
);
  localparam logic [ADDR_W-1:0] OFS_CTRL = ADDR_W'('h00);
  localparam logic [ADDR_W-1:0] OFS_TIM0 = ADDR_W'('h04);
  localparam logic [ADDR_W-1:0] OFS_TIM1 = ADDR_W'('h08);
  localparam logic [ADDR_W-1:0] OFS_TIM2 = ADDR_W'('h0C);
  localparam logic [ADDR_W-1:0] OFS_STAT = ADDR_W'('h10);
  localparam logic [ADDR_W-1:0] OFS_SUB  = ADDR_W'('h14);

  logic [DATA_W-1:0] ctrl_rd, tim0_rd, stat_rd;

  always_comb begin
    ctrl_rd       = cfg.ctrl_kept | CTRL_SET;
    ctrl_rd[0]    = ctrl_rd[0] | cfg.en;
    ctrl_rd[1]    = ctrl_rd[1] | cfg.mono;
    ctrl_rd[4:3]  = ctrl_rd[4:3] | cfg.mask;
    ctrl_rd[7]    = ctrl_rd[7] | cfg.tft;
    ctrl_rd[21:20]= ctrl_rd[21:20] | cfg.plm;
    ctrl_rd[23]   = ctrl_rd[23] | cfg.tft;

    tim0_rd       = {cfg.tim0_hi, cfg.width_m1};
    tim0_rd[3:0]  = TIM0_LOW;

    stat_rd       = '0;
    stat_rd[0]    = flags[FLG_FRAME];
    stat_rd[2]    = flags[FLG_SYNC];
    stat_rd[6]    = flags[FLG_PAL];

    unique case (addr)
      OFS_CTRL: rdata = ctrl_rd;
      OFS_TIM0: rdata = tim0_rd;
      OFS_TIM1: rdata = {cfg.tim1_hi, cfg.height_m1};
      OFS_TIM2: rdata = cfg.tim2 | TIM2_SET;
      OFS_STAT: rdata = stat_rd;
      OFS_SUB:  rdata = cfg.sub;
      default:  rdata = '0;
    endcase
  end
endmodule

// File: rtl/lcdc_regs_top.sv
module lcdc_regs_top
  import lcdc_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              evt_frame_done,
  input  logic              evt_palette_loaded,
  input  logic              evt_sync_error,
  output logic              irq,
  output logic              panel_en,
  output logic [1:0]        pal_mode,
  output logic              tft_sel,
  output logic              mono_sel,
  output logic [SIZE_W-1:0] width_m1,
  output logic [SIZE_W-1:0] height_m1
);
  cfg_t             cfg;
  logic             en_rise, en_fall, fall_sets_frame;
  logic [NFLAG-1:0] flags;

  lcdc_cfg_regs #(.ADDR_W(ADDR_W)) u_cfg (
    .clk               (clk),
    .rst_n             (rst_n),
    .wr_en             (reg_wr),
    .addr              (reg_addr),
    .wdata             (reg_wdata),
    .cfg_o             (cfg),
    .en_rise_o         (en_rise),
    .en_fall_o         (en_fall),
    .fall_sets_frame_o (fall_sets_frame)
  );

  lcdc_status_irq u_stat (
    .clk             (clk),
    .rst_n           (rst_n),
    .evt_frame       (evt_frame_done),
    .evt_pal         (evt_palette_loaded),
    .evt_sync        (evt_sync_error),
    .en_rise         (en_rise),
    .en_fall         (en_fall),
    .fall_sets_frame (fall_sets_frame),
    .mask            (cfg.mask),
    .flags_o         (flags),
    .irq_o           (irq)
  );

  lcdc_read_mux #(.ADDR_W(ADDR_W)) u_rd (
    .addr  (reg_addr),
    .cfg   (cfg),
    .flags (flags),
    .rdata (reg_rdata)
  );

  assign panel_en  = cfg.en;
  assign pal_mode  = cfg.plm;
  assign tft_sel   = cfg.tft;
  assign mono_sel  = cfg.mono;
  assign width_m1  = cfg.width_m1;
  assign height_m1 = cfg.height_m1;

  // R1: the active-matrix select always shows at both control bits
  a_r1_tft_mirror: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == ADDR_W'('h00)) |-> (reg_rdata[23] == 1'b1 || !tft_sel) && (reg_rdata[7] == tft_sel));
  // R5: a status write is ignored
  a_r5_status_write_inert: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == ADDR_W'('h10) && !evt_frame_done && !evt_palette_loaded &&
     !evt_sync_error) |=> $stable(flags));
endmodule

// File: tb/lcdc_regs_top_tb.sv
`timescale 1ns/100ps
module lcdc_regs_top_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_addr = 8'h10;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        ev_fd = 1'b0, ev_pal = 1'b0, ev_sync = 1'b0;
  logic        irq, panel_en, tft_sel, mono_sel;
  logic [1:0]  pal_mode;
  logic [9:0]  width_m1, height_m1;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  lcdc_regs_top u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .evt_frame_done(ev_fd), .evt_palette_loaded(ev_pal), .evt_sync_error(ev_sync),
    .irq(irq), .panel_en(panel_en), .pal_mode(pal_mode), .tft_sel(tft_sel),
    .mono_sel(mono_sel), .width_m1(width_m1), .height_m1(height_m1)
  );

  // behavioural model: raw words as last written, plus three flags
  logic [31:0] m_ctrl, m_t0, m_t1, m_t2, m_sub;
  bit m_fd, m_pal, m_sync, m_irq;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ctrl = 0; m_t0 = 0; m_t1 = 0; m_t2 = 0; m_sub = 0;
      m_fd = 0; m_pal = 0; m_sync = 0; m_irq = 0;
    end else begin
      bit was_en, rise, fall, new_irq;
      new_irq = (m_fd && m_ctrl[3]) || (m_pal && m_ctrl[4]) || m_sync;
      was_en = m_ctrl[0];
      rise = 0; fall = 0;
      if (reg_wr) begin
        case (reg_addr)
          8'h00: begin
            rise = reg_wdata[0] && !was_en;
            fall = !reg_wdata[0] && was_en;
            m_ctrl = reg_wdata;
          end
          8'h04: m_t0 = reg_wdata;
          8'h08: m_t1 = reg_wdata;
          8'h0C: m_t2 = reg_wdata;
          8'h14: m_sub = reg_wdata & 32'hA1FFFFFF;
          default: ;
        endcase
      end
      if (ev_fd)   m_fd = 1;
      if (ev_pal)  m_pal = 1;
      if (ev_sync) m_sync = 1;
      if (rise) begin m_fd = 0; m_pal = 0; end
      if (fall) begin
        m_sync = 0;
        if (m_ctrl[21:20] != 2'd1) m_fd = 1;
      end
      m_irq = new_irq;
    end
  end

  function automatic logic [31:0] exp_read(input logic [7:0] a);
    logic [31:0] w;
    case (a)
      8'h00: begin
        w = (m_ctrl & 32'h01CFF300) | (m_ctrl & 32'h0030009B) | 32'hFE000C34;
        if (m_ctrl[7]) w = w | 32'h00800000;
        return w;
      end
      8'h04: return m_t0 | 32'h0000000F;
      8'h08: return m_t1;
      8'h0C: return m_t2 | 32'hFC000000;
      8'h10: return {25'd0, m_pal, 3'd0, m_sync, 1'b0, m_fd};
      8'h14: return m_sub;
      default: return 32'd0;
    endcase
  endfunction

  function automatic string req_of(input logic [7:0] a);
    case (a)
      8'h00: return "R1";
      8'h04: return "R2";
      8'h08: return "R3";
      8'h0C: return "R4";
      8'h10: return "R5";
      8'h14: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h at %0t", req, what, act, exp, $time);
    end
  endtask

  // compare against the model on every clock, away from the edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(req_of(reg_addr), "read data", reg_rdata, exp_read(reg_addr));
      check("R8", "irq", {31'd0, irq}, {31'd0, m_irq});
      check("R12", "panel_en", {31'd0, panel_en}, {31'd0, m_ctrl[0]});
      check("R12", "pal_mode", {30'd0, pal_mode}, {30'd0, m_ctrl[21:20]});
      check("R12", "tft/mono", {30'd0, tft_sel, mono_sel}, {30'd0, m_ctrl[7], m_ctrl[1]});
      check("R12", "width", {22'd0, width_m1}, {22'd0, m_t0[9:0]});
      check("R12", "height", {22'd0, height_m1}, {22'd0, m_t1[9:0]});
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_wr = 0;
  endtask

  task automatic rd(input logic [7:0] a);
    @(posedge clk); #1;
    reg_addr = a;
  endtask

  task automatic pulse(input bit f, input bit p, input bit s);
    @(posedge clk); #1;
    ev_fd = f; ev_pal = p; ev_sync = s;
    @(posedge clk); #1;
    ev_fd = 0; ev_pal = 0; ev_sync = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    #1;
  endtask

  initial begin
    // R11: reset state seen at the ports
    idle(3);
    @(negedge clk);
    check("R11", "status in reset", reg_rdata, 32'd0);
    check("R11", "irq in reset", {31'd0, irq}, 32'd0);
    check("R11", "fields in reset", {panel_en, pal_mode, tft_sel, mono_sel, width_m1, height_m1}, 32'd0);
    reg_addr = 8'h04;
    #0.5;
    check("R11", "timing0 in reset", reg_rdata, 32'h0000000F);
    @(posedge clk); #1 rst_n = 1;

    // R1: control layout with the enable kept off
    wr(8'h00, 32'hFFFFFFFE); rd(8'h00); idle(2);
    wr(8'h00, 32'h00000082); rd(8'h00); idle(2);
    wr(8'h00, 32'h00200000); rd(8'h00); idle(2);
    // R2, R3, R4, R6: timing, size and subpanel words
    wr(8'h04, 32'hABCDE3F0); rd(8'h04); idle(2);
    wr(8'h08, 32'h12345678); rd(8'h08); idle(2);
    wr(8'h0C, 32'h00ABCDEF); rd(8'h0C); idle(2);
    wr(8'h14, 32'hFFFFFFFF); rd(8'h14); idle(2);
    wr(8'h14, 32'h5E000001); rd(8'h14); idle(2);
    // R5: a status write is ignored
    wr(8'h10, 32'hFFFFFFFF); rd(8'h10); idle(2);
    // R7: unmapped and unaligned offsets
    wr(8'h18, 32'hFFFFFFFF); wr(8'h03, 32'hFFFFFFFF); wr(8'hFC, 32'h12345678);
    rd(8'h18); idle(1); rd(8'h03); idle(1); rd(8'hFC); idle(1);
    rd(8'h04); idle(1); rd(8'h00); idle(1);

    // R5, R8: frame done masked, then unmasked
    rd(8'h10);
    pulse(1, 0, 0); idle(3);
    wr(8'h00, 32'h00000008); idle(3);
    // palette loaded with mask bit 1
    wr(8'h00, 32'h00000010); pulse(0, 1, 0); idle(3);
    // R10: enable on clears both
    wr(8'h00, 32'h00000019); idle(3);
    // R8: sync error with mask off still interrupts
    wr(8'h00, 32'h00000001); pulse(0, 0, 1); idle(3);
    // R9: disable in mode 1 clears sync, leaves frame done
    wr(8'h00, 32'h00100000); idle(3);
    // R9: disable in mode 0 sets frame done
    wr(8'h00, 32'h00000009); idle(2);
    wr(8'h00, 32'h00000008); idle(3);
    // R10 override: enable on while frame/palette pulse
    @(posedge clk); #1;
    reg_wr = 1; reg_addr = 8'h00; reg_wdata = 32'h00000019; ev_fd = 1; ev_pal = 1;
    @(posedge clk); #1;
    reg_wr = 0; ev_fd = 0; ev_pal = 0; reg_addr = 8'h10; idle(3);
    // R9 override: disable while a sync error pulses
    @(posedge clk); #1;
    reg_wr = 1; reg_addr = 8'h00; reg_wdata = 32'h00200018; ev_sync = 1;
    @(posedge clk); #1;
    reg_wr = 0; ev_sync = 0; reg_addr = 8'h10; idle(3);
    // final sweep over every offset
    for (int a = 0; a < 32; a++) begin
      rd(8'(a)); idle(1);
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  // watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual %0d cycles expected fewer than 20000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule